// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst SRAM. It has two address strobes, one for the processor and one for the cache controller, and a new cycle starts when either strobe is accepted. At that point the block registers the external address and decides from three select inputs whether the device takes part in the cycle.

After a cycle has started, an advance input walks the internal address through a four-word burst. Only the two lowest address bits change. A static mode input sets the order of those bits. In linear order the two bits count up and wrap. In interleaved order the loaded value is XORed with the beat count.

All outputs come from registers and change on the clock edge that samples the inputs. The outputs are the internal address, a selected flag and a one-cycle start flag.

Top module: `sram_burst_seq`

## Requirements
- R1: While `rst_ni` is low, and before any start cycle, `addr_o` is 0, `sel_o` is 0 and `start_o` is 0.
- R2: A clock edge with `ads_ctrl_ni` low starts a cycle whatever the value of `ce_ni`. From the next cycle on, `addr_o` equals the `addr_i` sampled at that edge and the burst count restarts at beat 0. This also holds in the middle of a burst.
- R3: A clock edge with `ads_proc_ni` low starts a cycle only if `ce_ni` is also low. If `ce_ni` is high and `ads_ctrl_ni` is high, the processor strobe has no effect: `start_o` stays 0 and `addr_o` and `sel_o` behave as if the strobe were high.
- R4: After a start cycle, `sel_o` is 1 only if, at that edge, `ce_ni` was 0, `sel_hi_i` was 1 and `sel_lo_ni` was 0. In every other case `sel_o` is 0 after the start cycle.
- R5: While selected, on an edge where neither strobe is accepted, `adv_ni`=0 moves the burst one beat forward. `adv_ni`=1 leaves `addr_o` unchanged, which suspends the burst.
- R6: With `order_i`=0 (linear), each beat adds 1 modulo 4 to the two low bits. A start value of 01 gives 01, 10, 11, 00 and then wraps to 01.
- R7: With `order_i`=1 (interleaved), the two low bits are the loaded value XOR the beat count 0, 1, 2, 3. A start value of 01 gives 01, 00, 11, 10 and then wraps to 01.
- R8: During a burst, bits `ADDR_W-1:2` of `addr_o` never change. No carry passes out of the two low bits.
- R9: While deselected (`sel_o`=0), `adv_ni` has no effect. `addr_o` and `sel_o` hold their values until a start cycle.
- R10: `start_o` is 1 for exactly the one cycle after each edge that starts a cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| ads_proc_ni | input | 1 | Processor address strobe, active low, gated by `ce_ni` |
| ads_ctrl_ni | input | 1 | Cache-controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Chip enable, active low |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_ni | input | 1 | Chip select, active low |
| order_i | input | 1 | Burst order, static: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Internal array address |
| sel_o | output | 1 | Device selected for the current cycle |
| start_o | output | 1 | A cycle started on the previous edge |

## Verification
The bench goes after these corner cases:
- A processor strobe with chip enable high. A design that forgets the gating would start a spurious cycle or deselect the device.
- A controller strobe with chip enable high. A design that gates this strobe too would keep an old selected burst running.
- Bursts that wrap past the fourth beat in both orders, using start values that make the linear and XOR sequences differ. A design with the orders swapped, or one that lets the count carry into the upper address bits, gives the wrong address.
- A suspend in the middle of a burst, a restart in the middle of a burst, and advance pulses while deselected. A design that keeps counting through these shows a moving address where it should hold.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [1:0] seq_lo(input logic [1:0] base, input logic [1:0] cnt,
                                        input burst_order_e ord);
    return (ord == ORD_XOR) ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/seq_start_decode.sv
module seq_start_decode (
  input  logic ads_proc_ni,
  input  logic ads_ctrl_ni,
  input  logic ce_ni,
  input  logic sel_hi_i,
  input  logic sel_lo_ni,
  output logic load_o,
  output logic chip_sel_o
);
  logic proc_ok;
  // processor strobe only counts with chip enable asserted
  assign proc_ok    = ~ads_proc_ni & ~ce_ni;
  assign load_o     = ~ads_ctrl_ni | proc_ok;
  assign chip_sel_o = ~ce_ni & sel_hi_i & ~sel_lo_ni;
endmodule

// File: rtl/seq_burst_ctr.sv
module seq_burst_ctr
  import sram_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] base_lo_i,
  input  logic             order_i,
  output logic [CNT_W-1:0] lo_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (CNT_W == 2) begin : g_two
      assign lo_o = seq_lo(base_lo_i, cnt_q, burst_order_e'(order_i));
    end else begin : g_wide
      assign lo_o = order_i ? (base_lo_i ^ cnt_q) : (base_lo_i + cnt_q);
    end
  endgenerate

  // R5
  step_ctr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_ni,
  input  logic              ads_ctrl_ni,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              start_o
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              load, chip_sel, step;
  logic [ADDR_W-1:0] base_q;
  logic              sel_q, start_q;
  logic [CNT_W-1:0]  lo;

  seq_start_decode u_dec (
    .ads_proc_ni(ads_proc_ni),
    .ads_ctrl_ni(ads_ctrl_ni),
    .ce_ni      (ce_ni),
    .sel_hi_i   (sel_hi_i),
    .sel_lo_ni  (sel_lo_ni),
    .load_o     (load),
    .chip_sel_o (chip_sel)
  );

  // deselected state ignores advance
  assign step = sel_q & ~load & ~adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      sel_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= load;
      if (load) begin
        base_q <= addr_i;
        sel_q  <= chip_sel;
      end
    end
  end

  seq_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (load),
    .step_i   (step),
    .base_lo_i(base_q[CNT_W-1:0]),
    .order_i  (order_i),
    .lo_o     (lo)
  );

  assign addr_o  = {base_q[ADDR_W-1:CNT_W], lo};
  assign sel_o   = sel_q;
  assign start_o = start_q;

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> addr_o == $past(addr_i));
  // R3
  proc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_ctrl_ni && ce_ni) |=> !start_o);
  // R4
  sel_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> sel_o == $past(chip_sel));
  // R5
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_ni) |=> $stable(addr_o));
  // R8
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W]));
  // R9
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && !load) |=> ($stable(addr_o) && !sel_o));
  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> !start_o);
  initial assert (HI_W > 0) else $error("ADDR_W must exceed CNT_W");
endmodule

// File: tb/tb_sram_burst_seq.sv
module tb_sram_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic ads_proc_ni = 1'b1, ads_ctrl_ni = 1'b1, adv_ni = 1'b1;
  logic ce_ni = 1'b1, sel_hi_i = 1'b0, sel_lo_ni = 1'b1, order_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic sel_o, start_o;

  int checks = 0, failures = 0, cycles = 0;
  logic [AW-1:0] m_base = '0;
  int m_cnt = 0;
  bit m_sel = 0, m_start = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .ads_proc_ni(ads_proc_ni),
    .ads_ctrl_ni(ads_ctrl_ni), .adv_ni(adv_ni), .ce_ni(ce_ni), .sel_hi_i(sel_hi_i),
    .sel_lo_ni(sel_lo_ni), .order_i(order_i), .addr_o(addr_o), .sel_o(sel_o),
    .start_o(start_o)
  );

  task automatic check(string req, string what, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = order_i ? (m_base[1:0] ^ 2'(m_cnt)) : (m_base[1:0] + 2'(m_cnt));
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic compare(string req);
    check(req, "addr_o", addr_o, model_addr());
    check(req, "sel_o", sel_o, m_sel);
    check(req, "start_o", start_o, m_start);
  endtask

  // drive after negedge, model at posedge, compare at next negedge
  task automatic cyc(string req, bit ctrl_n, bit proc_n, bit ce_n, bit hi, bit lo_n,
                     bit adv_n, logic [AW-1:0] a);
    ads_ctrl_ni = ctrl_n; ads_proc_ni = proc_n; ce_ni = ce_n;
    sel_hi_i = hi; sel_lo_ni = lo_n; adv_ni = adv_n; addr_i = a;
    @(posedge clk);
    if (!ctrl_n || (!proc_n && !ce_n)) begin
      m_base = a; m_cnt = 0; m_sel = !ce_n && hi && !lo_n; m_start = 1;
    end else begin
      m_start = 0;
      if (m_sel && !adv_n) m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(string req, bit adv_n);
    cyc(req, 1, 1, 1, 0, 1, adv_n, 18'h3ffff);
  endtask

  task automatic do_reset(bit ord);
    rst_ni = 1'b0; order_i = ord;
    m_base = '0; m_cnt = 0; m_sel = 0; m_start = 0;
    #1;
    compare("R1");
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // R1
    @(negedge clk);
    do_reset(0);
    idle("R9", 0);

    // R6 linear from 01, explicit sequence
    cyc("R2", 1, 0, 0, 1, 0, 1, 18'h12341);
    check("R4", "sel after proc start", sel_o, 1);
    check("R6", "lo beat0", addr_o[1:0], 2'b01);
    cyc("R6", 1, 1, 0, 1, 0, 0, 18'h0); check("R6", "lo beat1", addr_o[1:0], 2'b10);
    cyc("R6", 1, 1, 0, 1, 0, 0, 18'h0); check("R6", "lo beat2", addr_o[1:0], 2'b11);
    cyc("R6", 1, 1, 0, 1, 0, 0, 18'h0); check("R6", "lo beat3", addr_o[1:0], 2'b00);
    check("R8", "upper bits", addr_o[AW-1:2], 18'h12341 >> 2);
    cyc("R6", 1, 1, 0, 1, 0, 0, 18'h0); check("R6", "wrap", addr_o[1:0], 2'b01);
    check("R10", "start low mid burst", start_o, 0);

    // R5 suspend then resume
    cyc("R5", 1, 1, 1, 0, 1, 1, 18'h0);
    cyc("R5", 1, 1, 1, 0, 1, 1, 18'h0);
    cyc("R5", 1, 1, 1, 0, 1, 0, 18'h0);

    // R3 proc strobe with ce high ignored, burst continues
    cyc("R3", 1, 0, 1, 1, 0, 0, 18'h00aaa);
    check("R3", "no start", start_o, 0);
    cyc("R3", 1, 0, 1, 1, 0, 1, 18'h00bbb);

    // R2 ctrl strobe restarts mid burst
    cyc("R2", 1, 1, 0, 1, 0, 0, 18'h0);
    cyc("R2", 0, 1, 0, 1, 0, 0, 18'h2fff3);
    check("R10", "start pulse", start_o, 1);
    cyc("R8", 1, 1, 0, 1, 0, 0, 18'h0);
    check("R8", "no carry", addr_o, 18'h2fff0);

    // R4 deselect variants, R2 ctrl strobe works with ce high
    cyc("R4", 0, 1, 1, 1, 0, 0, 18'h01110);
    check("R4", "ce high desel", sel_o, 0);
    cyc("R9", 1, 1, 1, 0, 1, 0, 18'h0);
    cyc("R9", 1, 1, 1, 0, 1, 0, 18'h0);
    cyc("R4", 0, 1, 0, 0, 0, 0, 18'h02220);
    cyc("R9", 1, 1, 0, 1, 0, 0, 18'h0);
    cyc("R4", 1, 0, 0, 1, 1, 0, 18'h03330);
    cyc("R9", 1, 1, 0, 1, 0, 0, 18'h0);
    cyc("R4", 0, 0, 0, 1, 0, 1, 18'h04442);
    check("R4", "selected", sel_o, 1);

    // R7 interleaved
    do_reset(1);
    cyc("R7", 0, 1, 0, 1, 0, 1, 18'h15551);
    check("R7", "lo beat0", addr_o[1:0], 2'b01);
    cyc("R7", 1, 1, 0, 1, 0, 0, 18'h0); check("R7", "lo beat1", addr_o[1:0], 2'b00);
    cyc("R7", 1, 1, 0, 1, 0, 0, 18'h0); check("R7", "lo beat2", addr_o[1:0], 2'b11);
    cyc("R7", 1, 1, 0, 1, 0, 1, 18'h0);
    cyc("R7", 1, 1, 0, 1, 0, 0, 18'h0); check("R7", "lo beat3", addr_o[1:0], 2'b10);
    cyc("R7", 1, 1, 0, 1, 0, 0, 18'h0); check("R7", "wrap", addr_o[1:0], 2'b01);
    for (int b = 0; b < 4; b++) begin
      cyc("R7", 0, 1, 0, 1, 0, 1, 18'h20000 | 18'(b) | 18'(b << 4));
      for (int k = 0; k < 5; k++) idle("R7", 0);
    end

    // linear sweep of all start values
    do_reset(0);
    for (int b = 0; b < 4; b++) begin
      cyc("R6", 1, 0, 0, 1, 0, 1, 18'h30000 | 18'(b) | 18'(b << 8));
      for (int k = 0; k < 5; k++) idle("R6", (k == 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule